// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into bytes. A two-flop synchronizer brings the line into the clock domain. An enable at sixteen times the bit rate, supplied by an external divider, paces the receive state machine. The machine confirms each start bit at its midpoint. It then takes each data bit, the optional parity bit and the stop bit at the midpoint of that bit.

Each finished character enters a small queue. The character carries its own framing, parity and break flags, so the error report always matches the character that software is about to read. A line held low for a whole character produces one zero entry marked as a break. The receiver then stays locked until the line goes high again.

A character that completes while the queue is full is dropped and raises a sticky overrun flag, and the queued entries are left as they were. A one-cycle clear strobe hides the flags of the current head and drops the overrun flag.

Top module: `rxq_top`

## Requirements
- R1: After reset `empty_o` is 1, `full_o` is 0 and `status_o` is 4'b0000.
- R2: The receiver accepts a start bit only if the line is still low when it samples 8 enable ticks after it first sees the line low. A low pulse shorter than that is discarded and adds no entry.
- R3: Data is taken least significant bit first. The character length is `wlen_i`+5 bits (00=5, 01=6, 10=7, 11=8). The value appears right-aligned on `data_o` with the unused upper bits at 0.
- R4: With `par_en_i`=1 and `par_stick_i`=0, the expected parity bit makes the total number of ones in data plus parity even when `par_even_i`=1, and odd when `par_even_i`=0. A mismatch sets `status_o[1]` for that entry.
- R5: With `par_en_i`=1 and `par_stick_i`=1, the expected parity bit is the inverse of `par_even_i`. A mismatch sets `status_o[1]`.
- R6: A stop bit sampled as 0, on a character that is not a break, sets `status_o[0]` for that entry.
- R7: A break is a character whose start, data, parity and stop samples are all 0. It pushes exactly one entry with data 0 and flags framing=0, parity=0, break=1 (`status_o[2]`).
- R8: After a break no entry is added while the line stays low. Reception resumes only after the line returns high and a new valid start bit arrives.
- R9: A character that completes while the queue is full sets `status_o[3]` and is dropped. The queued entries keep their data and order.
- R10: `status_o[2:0]` shows the flags of the entry at the head of the queue (bit 0 framing, bit 1 parity, bit 2 break). They read 0 when the queue is empty, and follow the new head after `pop_i`.
- R11: An `err_clr_i` pulse drops `status_o[3]`. It also forces `status_o[2:0]` to 0 until the head entry changes. An overrun in the same cycle as the clear keeps `status_o[3]` set.
- R12: The receive state advances only in cycles where `os_tick_i` is 1. Characters are received correctly for any tick period, with a bit lasting 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Enable at 16x the bit rate |
| rx_i | input | 1 | Asynchronous serial line, high when idle |
| wlen_i | input | 2 | Character length code (length = code + 5) |
| par_en_i | input | 1 | A parity bit follows the data |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| pop_i | input | 1 | Remove the head entry (ignored when empty) |
| err_clr_i | input | 1 | Clear strobe for the status flags |
| data_o | output | 8 | Head entry data |
| empty_o | output | 1 | Queue holds no entry |
| full_o | output | 1 | Queue holds its maximum number of entries |
| status_o | output | 4 | {overrun, break, parity, framing} |

## Verification
A table of characters covers every character length, even, odd and stick parity with correct and flipped parity bits, a missing stop bit, and tick periods of 1, 2 and 3 clocks. Together these separate errors in bit order, alignment and masking from errors in parity polarity, and separate stick mode from normal parity. Directed sequences then send a short low glitch, a long low line before and after its single break entry, a fifth character into a full queue, and a framing-error entry followed by a parity-error entry. These show whether the flags stay with their own entry across a clear and a pop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              be;
    logic              pe;
    logic              fe;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_LOCK
  } rx_state_e;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rxq_deser.sv
module rxq_deser
  import rxq_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic [1:0] wlen_i,
  input  logic      par_en_i,
  input  logic      par_even_i,
  input  logic      par_stick_i,
  output logic      done_o,
  output rx_entry_t entry_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q, zero_q, perr_q, done_q;
  rx_entry_t         entry_q;

  logic [2:0] last_bit, shamt;
  logic       exp_par;

  assign last_bit = 3'(wlen_i) + 3'd4;
  assign shamt    = 3'd3 - 3'(wlen_i);
  assign exp_par  = par_stick_i ? ~par_even_i : (par_even_i ? par_q : ~par_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) state_q <= S_START;
          end
          S_START: begin
            if (cnt_q == MID) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= S_IDLE;  // glitch
              end else begin
                state_q <= S_DATA;
                bit_q   <= '0;
                par_q   <= 1'b0;
                zero_q  <= 1'b1;
                perr_q  <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              sh_q   <= {rx_i, sh_q[DATA_W-1:1]};
              par_q  <= par_q ^ rx_i;
              zero_q <= zero_q & ~rx_i;
              if (bit_q == last_bit) state_q <= par_en_i ? S_PAR : S_STOP;
              else                   bit_q   <= bit_q + 3'd1;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              perr_q  <= rx_i ^ exp_par;
              zero_q  <= zero_q & ~rx_i;
              state_q <= S_STOP;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              done_q <= 1'b1;
              if (!rx_i && zero_q) begin
                entry_q <= '{be: 1'b1, pe: 1'b0, fe: 1'b0, data: '0};
                state_q <= S_LOCK;
              end else begin
                entry_q <= '{be: 1'b0, pe: perr_q, fe: ~rx_i, data: sh_q >> shamt};
                state_q <= S_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_LOCK: begin
            if (rx_i) state_q <= S_IDLE;  // wait for mark
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign entry_o = entry_q;

  AST_LOCK_AFTER_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && entry_q.be) |-> (state_q == S_LOCK)); // R8
  AST_LOCK_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK && !rx_i) |=> (state_q == S_LOCK && !done_q)); // R8
  AST_TICK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(state_q) && $stable(cnt_q))); // R12
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rx_entry_t        wdata_i,
  input  logic             pop_i,
  output rx_entry_t        head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [LW-1:0]   cnt_q;
  logic            do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o); // R10
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              os_tick_i,
  input  logic              rx_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  input  logic              pop_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [3:0]        status_o
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic      rx_s, done, push, ovr, oe_q, hide_q, show;
  rx_entry_t entry, head;
  logic [LW-1:0] level;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  rxq_deser #(.OS_RATE(OS_RATE)) u_deser (
    .clk_i, .rst_ni, .tick_i(os_tick_i), .rx_i(rx_s),
    .wlen_i, .par_en_i, .par_even_i, .par_stick_i,
    .done_o(done), .entry_o(entry)
  );

  assign push = done && !full_o;
  assign ovr  = done && full_o;

  rxq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(entry), .pop_i,
    .head_o(head), .empty_o, .full_o, .level_o(level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      hide_q <= 1'b0;
    end else begin
      if (ovr)            oe_q <= 1'b1;  // new event beats clear
      else if (err_clr_i) oe_q <= 1'b0;
      if (err_clr_i)                                 hide_q <= 1'b1;
      else if ((pop_i && !empty_o) || (push && empty_o)) hide_q <= 1'b0;
    end
  end

  assign show     = !empty_o && !hide_q;
  assign data_o   = head.data;
  assign status_o = {oe_q, show ? {head.be, head.pe, head.fe} : 3'b000};

  AST_BREAK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && entry.be) |-> (entry.data == '0 && !entry.fe && !entry.pe)); // R7
  AST_OVR_KEEPS_FIFO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr && !pop_i) |=> $stable(level)); // R9
  AST_OVR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr |=> status_o[3]); // R9
  AST_CLR_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> (status_o[2:0] == 3'b000)); // R11
  AST_CLR_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !ovr) |=> !status_o[3]); // R11
  AST_EMPTY_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (status_o[2:0] == 3'b000)); // R10
endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       os_tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] wlen_i = 2'd3;
  logic       par_en_i = 1'b0, par_even_i = 1'b0, par_stick_i = 1'b0;
  logic       pop_i = 1'b0, err_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       empty_o, full_o;
  logic [3:0] status_o;

  int tests = 0, fails = 0;
  int tick_per = 1, tick_cnt = 0;

  always #4 clk_i = ~clk_i;

  rxq_top dut_i (
    .clk_i, .rst_ni, .os_tick_i, .rx_i, .wlen_i, .par_en_i, .par_even_i,
    .par_stick_i, .pop_i, .err_clr_i, .data_o, .empty_o, .full_o, .status_o
  );

  always @(negedge clk_i) begin
    if (tick_cnt >= tick_per - 1) begin tick_cnt = 0; os_tick_i = 1'b1; end
    else begin tick_cnt = tick_cnt + 1; os_tick_i = 1'b0; end
  end

  // {wlen[16:15], pen[14], eps[13], sps[12], flip[11], stop[10], tp[9:8], data[7:0]}
  localparam logic [16:0] VECS [10] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hA5},  // R3
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hFF},  // R3
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'hC3},  // R3
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h6B},  // R4
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 8'h3C},  // R4
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 8'h01},  // R5
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 8'h80},  // R5
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h96},  // R6
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 8'h5C},  // R12
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h12}   // R12
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int n);
    rx_i = b;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_char(input logic [1:0] wl, input logic pen, eps, sps, flip, stp,
                           input logic [7:0] d, input int tp);
    logic [7:0] dm;
    logic pb;
    int bl;
    bl = 16 * tp;
    tick_per = tp;
    wlen_i = wl; par_en_i = pen; par_even_i = eps; par_stick_i = sps;
    dm = d & (8'hFF >> (3 - wl));
    pb = sps ? ~eps : (eps ? ^dm : ~^dm);
    pb = pb ^ flip;
    hold(1'b0, bl);
    for (int i = 0; i < 5 + wl; i++) hold(d[i], bl);
    if (pen) hold(pb, bl);
    hold(stp, bl);
    hold(1'b1, 2 * bl);
  endtask

  task automatic pulse_pop();
    pop_i = 1'b1; @(negedge clk_i); pop_i = 1'b0; @(negedge clk_i);
  endtask

  task automatic pulse_clr();
    err_clr_i = 1'b1; @(negedge clk_i); err_clr_i = 1'b0; @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 status", status_o, 0);

    // vector walk
    for (int v = 0; v < 10; v++) begin
      logic [16:0] e;
      logic [7:0] expd;
      e = VECS[v];
      send_char(e[16:15], e[14], e[13], e[12], e[11], e[10], e[7:0], int'(e[9:8]));
      expd = e[7:0] & (8'hFF >> (3 - e[16:15]));
      chk($sformatf("R3/R12 vec%0d present", v), empty_o, 0);
      chk($sformatf("R3/R12 vec%0d data", v), data_o, expd);
      chk($sformatf("R4/R5/R6 vec%0d flags", v), status_o,
          {1'b0, 1'b0, e[14] & e[11], ~e[10]});
      pulse_pop();
      chk($sformatf("R10 vec%0d drained", v), empty_o, 1);
    end
    tick_per = 1;

    // R2: short glitch
    hold(1'b0, 5);
    hold(1'b1, 64);
    chk("R2 glitch rejected", empty_o, 1);

    // R7/R8: break
    wlen_i = 2'd3; par_en_i = 1'b0;
    hold(1'b0, 12 * 16);
    chk("R7 break entry", empty_o, 0);
    chk("R7 break data", data_o, 8'h00);
    chk("R7 break flags", status_o, 4'b0100);
    pulse_pop();
    hold(1'b0, 20 * 16);
    chk("R8 locked while low", empty_o, 1);
    hold(1'b1, 32);
    chk("R8 no entry on mark", empty_o, 1);
    send_char(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1);
    chk("R8 resumes", data_o, 8'h5A);
    chk("R8 resumes flags", status_o, 0);
    pulse_pop();

    // R9: overrun
    for (int k = 1; k <= 4; k++)
      send_char(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'(k * 8'h11), 1);
    chk("R9 full", full_o, 1);
    chk("R9 no overrun yet", status_o[3], 0);
    send_char(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 1);
    chk("R9 overrun flag", status_o[3], 1);
    for (int k = 1; k <= 4; k++) begin
      chk($sformatf("R9 kept entry %0d", k), data_o, 8'(k * 8'h11));
      pulse_pop();
    end
    chk("R9 dropped char", empty_o, 1);
    chk("R9 overrun sticky", status_o[3], 1);
    pulse_clr();
    chk("R11 overrun cleared", status_o, 0);

    // R10/R11: per-entry flags, clear and head change
    send_char(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 1);
    send_char(2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h42, 1);
    chk("R10 head framing", status_o, 4'b0001);
    chk("R10 head data", data_o, 8'h81);
    pulse_clr();
    chk("R11 head hidden", status_o, 0);
    chk("R11 entry kept", data_o, 8'h81);
    pulse_pop();
    chk("R10 next head parity", status_o, 4'b0010);
    chk("R10 next head data", data_o, 8'h42);
    pulse_pop();
    chk("R10 empty no flags", status_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule